// File: doc/BRIEF.md
# Distributed-queue bus access controller

This controller sits at one node of a shared cell bus on which all payload flows downstream and all access requests flow upstream on a separate request channel. Each priority level has a counter of the requests that arrived from further downstream. Each empty slot that passes the node unused pays off one of those requests. Every node therefore holds its share of one global first-come, first-served queue, and no central arbiter is needed.

When the local logic has a cell ready at some priority, the controller takes note of it. It raises a request toward the upstream nodes in the first free position of the request channel. It copies the outstanding request count into a countdown. Empty slots then go past unused until the countdown reaches zero. The next empty slot is claimed: the controller marks it busy and the attached datapath puts its cell into it. The priority levels are strictly ordered. While any higher level has requests waiting or a cell queued, every lower level is frozen. It neither counts down nor claims a slot.

The cell datapath, cell storage and line signalling are outside this block. The controller only observes the slot and request streams and issues grants.

Top module: `dqbus_access_ctrl`

## Requirements
- R1: After reset all request counters and countdowns are zero. No cell is queued, no local request is pending, `grant_o` and `busy_o` are all zero, and `rq_out_bits_o` is zero.
- R2: `rq_out_valid_o` equals `rq_in_valid_i` in the same cycle. While that is high, bit p of `rq_out_bits_o` is the OR of `rq_in_bits_i[p]` and the node's pending request at priority p. While it is low, `rq_out_bits_o` is zero. Bit p of either request bus belongs to priority p, and a higher index means a higher priority.
- R3: A pending local request at priority p is written into the first request slot (`rq_in_valid_i` high) whose incoming bit p is clear. It is cleared at the end of that cycle. A request slot whose bit p is already set passes through and leaves the request pending.
- R4: While priority p has no queued cell, its request counter rises by one for each request slot that carries bit p. It falls by one for each empty slot (`slot_valid_i` high, `slot_busy_i` low) that passes ungranted while priority p is not held. It stops at zero and at its maximum value.
- R5: A `cell_new_i[p]` strobe is accepted only when priority p has neither a queued cell nor a pending request. On acceptance the request count moves into the countdown, the counter restarts at zero, and `busy_o[p]` rises in the next cycle. A strobe at any other time is ignored.
- R6: While a cell is queued at priority p, each ungranted empty slot that passes while p is not held lowers the countdown by one. Requests arriving at priority p in that time build up in the request counter and apply to the next cell.
- R7: In a cycle with an empty slot, priority p is granted (`grant_o[p]` high, `slot_mark_o` high) exactly when it has a queued cell, its countdown is zero and it is not held. The queued cell is released at the end of that cycle.
- R8: A slot that arrives busy passes with `slot_mark_o` high, grants nothing and leaves every counter unchanged.
- R9: Priority p is held while any higher priority has a non-zero request count or a queued cell. A held priority neither decrements nor is granted. At most one grant is issued per slot, and it goes to the highest eligible priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_valid_i | input | 1 | A downstream slot is present this cycle |
| slot_busy_i | input | 1 | The present slot already carries a cell |
| slot_mark_o | output | 1 | Busy marker passed on downstream (incoming busy or claimed here) |
| rq_in_valid_i | input | 1 | A request slot arrives from the downstream neighbour |
| rq_in_bits_i | input | NPRI | Request bits per priority in the arriving request slot |
| rq_out_valid_o | output | 1 | Request slot passed to the upstream neighbour |
| rq_out_bits_o | output | NPRI | Merged request bits toward the upstream neighbour |
| cell_new_i | input | NPRI | Strobe: a local cell of this priority is ready |
| grant_o | output | NPRI | The present empty slot is claimed for this priority |
| busy_o | output | NPRI | A local cell or its request is still outstanding at this priority |

## Verification
Two collisions between functions get directed cycles of their own. In the first, a request slot with a priority's bit already set arrives while that priority's own request is pending and its cell is being counted down. The bench judges that the incoming bit is forwarded, that the local request stays pending until a later clear slot, and that the arriving request is counted toward the following cell rather than the current one. In the second, cells at both priorities become ready in one cycle, or a low cell waits behind a high request count. The bench checks slot by slot that the high level takes the first empty slot and that the low level claims only the slot after the high demand has drained.

// File: rtl/dqb_pkg.sv
package dqb_pkg;

   // Status one priority lane hands to the slot arbiter each cycle.
   typedef struct packed {
      logic queued;    // a local cell waits for a slot
      logic cd_zero;   // its countdown has run out
      logic demand;    // queued cell or non-zero request count
   } prio_stat_t;

   localparam int DEF_NPRI  = 2;
   localparam int DEF_CNT_W = 6;

endpackage

// File: rtl/dqb_rq_merge.sv
module dqb_rq_merge #(
   parameter int NPRI = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rq_in_valid,
   input  logic [NPRI-1:0] rq_in_bits,
   input  logic [NPRI-1:0] accept,
   output logic            rq_out_valid,
   output logic [NPRI-1:0] rq_out_bits,
   output logic [NPRI-1:0] pend
);

   logic [NPRI-1:0] pend_d;

   assign rq_out_valid = rq_in_valid;
   assign rq_out_bits  = rq_in_valid ? (rq_in_bits | pend) : '0;

   generate
      for (genvar p = 0; p < NPRI; p++) begin : g_lane
         always_comb begin
            pend_d[p] = pend[p];
            if (accept[p])
               pend_d[p] = 1'b1;
            else if (rq_in_valid && !rq_in_bits[p])
               pend_d[p] = 1'b0;
         end

         // R3: a clear position in a request slot carries the pending request away
         p_pend_sent_r3: assert property (@(posedge clk) disable iff (!rst_n)
            pend[p] && rq_in_valid && !rq_in_bits[p] |=> !pend[p]);

         // R3: an occupied position leaves the request pending
         p_pend_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
            pend[p] && rq_in_valid && rq_in_bits[p] |=> pend[p]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= pend_d;
   end

   // R2: bits from downstream are never dropped on the way upstream
   p_fwd_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rq_in_valid |-> ((rq_out_bits & rq_in_bits) == rq_in_bits));

endmodule

// File: rtl/dqb_prio_ctr.sv
module dqb_prio_ctr #(
   parameter int CNT_W = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_in,
   input  logic                new_cell,
   input  logic                pend,
   input  logic                empty_pass,
   input  logic                held,
   input  logic                grant,
   output dqb_pkg::prio_stat_t stat,
   output logic                accept
);

   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] rc_q, rc_d, cd_q, cd_d;
   logic             queued_q, queued_d;
   logic             dec;

   always_comb begin
      dec      = empty_pass & ~held;
      accept   = new_cell & ~queued_q & ~pend;
      rc_d     = rc_q;
      cd_d     = cd_q;
      queued_d = queued_q;
      if (queued_q) begin
         if (req_in && rc_q != CNT_MAX) rc_d = rc_q + CNT_ONE;
         if (dec && cd_q != CNT_ZERO)   cd_d = cd_q - CNT_ONE;
         if (grant)                     queued_d = 1'b0;
      end else begin
         unique case ({req_in, dec})
            2'b10:   if (rc_q != CNT_MAX)  rc_d = rc_q + CNT_ONE;
            2'b01:   if (rc_q != CNT_ZERO) rc_d = rc_q - CNT_ONE;
            default: rc_d = rc_q;
         endcase
         if (accept) begin
            queued_d = 1'b1;
            cd_d     = (dec && rc_q != CNT_ZERO) ? rc_q - CNT_ONE : rc_q;
            rc_d     = req_in ? CNT_ONE : CNT_ZERO;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rc_q     <= '0;
         cd_q     <= '0;
         queued_q <= 1'b0;
      end else begin
         rc_q     <= rc_d;
         cd_q     <= cd_d;
         queued_q <= queued_d;
      end
   end

   assign stat.queued  = queued_q;
   assign stat.cd_zero = (cd_q == CNT_ZERO);
   assign stat.demand  = queued_q | (rc_q != CNT_ZERO);

   // R7: a running countdown blocks the grant
   p_cd_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      queued_q && cd_q != CNT_ZERO |-> !grant);

   // R4: the request counter never wraps below zero
   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !queued_q && rc_q == CNT_ZERO && !req_in |=> rc_q == CNT_ZERO);

   // R9: a held lane keeps its countdown
   p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      queued_q && held |=> cd_q == $past(cd_q));

   // R8: a busy slot leaves the countdown alone
   p_busy_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      queued_q && !empty_pass |=> cd_q == $past(cd_q));

endmodule

// File: rtl/dqb_slot_arb.sv
module dqb_slot_arb #(
   parameter int NPRI = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            slot_valid,
   input  logic                            slot_busy,
   input  dqb_pkg::prio_stat_t [NPRI-1:0]  stat,
   output logic [NPRI-1:0]                 grant,
   output logic [NPRI-1:0]                 held,
   output logic                            empty_pass,
   output logic                            slot_mark
);

   logic empty;

   assign empty = slot_valid & ~slot_busy;

   generate
      for (genvar p = 0; p < NPRI; p++) begin : g_hold
         if (p == NPRI - 1) begin : g_top
            assign held[p] = 1'b0;
         end else begin : g_low
            assign held[p] = held[p+1] | stat[p+1].demand;
         end
         assign grant[p] = empty & stat[p].queued & stat[p].cd_zero & ~held[p];

         if (p < NPRI - 1) begin : g_chk
            // R9: a lower lane never wins while a higher one has demand
            p_low_yields_r9: assert property (@(posedge clk) disable iff (!rst_n)
               stat[p+1].demand |-> !grant[p]);
         end
      end
   endgenerate

   assign empty_pass = empty & ~(|grant);
   assign slot_mark  = slot_busy | (|grant);

   // R9: one slot, one owner
   p_single_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R7: grants only land on slots that arrived empty
   p_grant_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      |grant |-> slot_valid && !slot_busy);

endmodule

// File: rtl/dqbus_access_ctrl.sv
module dqbus_access_ctrl #(
   parameter int NPRI  = dqb_pkg::DEF_NPRI,
   parameter int CNT_W = dqb_pkg::DEF_CNT_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            slot_valid_i,
   input  logic            slot_busy_i,
   output logic            slot_mark_o,
   input  logic            rq_in_valid_i,
   input  logic [NPRI-1:0] rq_in_bits_i,
   output logic            rq_out_valid_o,
   output logic [NPRI-1:0] rq_out_bits_o,
   input  logic [NPRI-1:0] cell_new_i,
   output logic [NPRI-1:0] grant_o,
   output logic [NPRI-1:0] busy_o
);

   generate
      if (NPRI < 1 || NPRI > 8) begin : g_bad_npri
         $error("NPRI must lie between 1 and 8");
      end
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W must lie between 2 and 16");
      end
   endgenerate

   dqb_pkg::prio_stat_t [NPRI-1:0] stat;
   logic [NPRI-1:0] accept, pend, held;
   logic            empty_pass;

   dqb_rq_merge #(.NPRI(NPRI)) u_merge (
      .clk          (clk),
      .rst_n        (rst_n),
      .rq_in_valid  (rq_in_valid_i),
      .rq_in_bits   (rq_in_bits_i),
      .accept       (accept),
      .rq_out_valid (rq_out_valid_o),
      .rq_out_bits  (rq_out_bits_o),
      .pend         (pend)
   );

   generate
      for (genvar p = 0; p < NPRI; p++) begin : g_prio
         dqb_prio_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_in     (rq_in_valid_i & rq_in_bits_i[p]),
            .new_cell   (cell_new_i[p]),
            .pend       (pend[p]),
            .empty_pass (empty_pass),
            .held       (held[p]),
            .grant      (grant_o[p]),
            .stat       (stat[p]),
            .accept     (accept[p])
         );
         assign busy_o[p] = stat[p].queued | pend[p];

         // R5: a strobe while busy is not taken again
         p_no_double_r5: assert property (@(posedge clk) disable iff (!rst_n)
            busy_o[p] |-> !accept[p]);
      end
   endgenerate

   dqb_slot_arb #(.NPRI(NPRI)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_valid (slot_valid_i),
      .slot_busy  (slot_busy_i),
      .stat       (stat),
      .grant      (grant_o),
      .held       (held),
      .empty_pass (empty_pass),
      .slot_mark  (slot_mark_o)
   );

   // R8: a busy slot stays busy downstream
   p_busy_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid_i && slot_busy_i |-> slot_mark_o && grant_o == '0);

endmodule

// File: tb/sim_dqbus_access_ctrl.sv
module sim_dqbus_access_ctrl;

   localparam int CLK_P = 10;
   localparam int NP    = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          slot_valid_i = 1'b0, slot_busy_i = 1'b0, rq_in_valid_i = 1'b0;
   logic [NP-1:0] rq_in_bits_i = '0, cell_new_i = '0;
   logic          slot_mark_o, rq_out_valid_o;
   logic [NP-1:0] rq_out_bits_o, grant_o, busy_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   dqbus_access_ctrl #(.NPRI(NP), .CNT_W(4)) u0 (
      .clk(clk), .rst_n(rst_n),
      .slot_valid_i(slot_valid_i), .slot_busy_i(slot_busy_i), .slot_mark_o(slot_mark_o),
      .rq_in_valid_i(rq_in_valid_i), .rq_in_bits_i(rq_in_bits_i),
      .rq_out_valid_o(rq_out_valid_o), .rq_out_bits_o(rq_out_bits_o),
      .cell_new_i(cell_new_i), .grant_o(grant_o), .busy_o(busy_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one cycle of stimulus; outputs are settled and sampled before the next rising edge
   task automatic cyc(input bit sv, input bit sb, input bit rv,
                      input logic [NP-1:0] rb, input logic [NP-1:0] nc);
      @(negedge clk);
      slot_valid_i = sv; slot_busy_i = sb;
      rq_in_valid_i = rv; rq_in_bits_i = rb; cell_new_i = nc;
      #1;
   endtask

   task automatic t_reset();
      cyc(0, 0, 1, 2'b00, 2'b00);
      check("R1 grant", grant_o, 0);
      check("R1 busy", busy_o, 0);
      check("R1 rq_out", rq_out_bits_o, 0);
      @(negedge clk); rst_n = 1'b1;
      cyc(1, 0, 0, 2'b00, 2'b00);
      check("R1 no grant on empty slot", grant_o, 0);
   endtask

   task automatic t_basic();
      cyc(0, 0, 0, 2'b00, 2'b01);
      cyc(1, 0, 0, 2'b00, 2'b00);
      check("R7 grant lo", grant_o, 1);
      check("R7 slot mark", slot_mark_o, 1);
      check("R5 busy after accept", busy_o, 1);
      cyc(0, 0, 1, 2'b00, 2'b00);
      check("R2 rq_out_valid", rq_out_valid_o, 1);
      check("R3 request inserted", rq_out_bits_o, 1);
      cyc(0, 0, 0, 2'b00, 2'b00);
      check("R2 bits zero without slot", rq_out_bits_o, 0);
      check("R3 pend cleared", busy_o, 0);
   endtask

   task automatic t_count();
      for (int i = 0; i < 3; i++) begin
         cyc(0, 0, 1, 2'b01, 2'b00);
         check("R2 forward bit", rq_out_bits_o, 1);
      end
      cyc(1, 1, 0, 2'b00, 2'b00);
      check("R8 busy slot mark", slot_mark_o, 1);
      check("R8 busy slot no grant", grant_o, 0);
      cyc(0, 0, 0, 2'b00, 2'b01);            // cd=3, rc=0
      cyc(1, 0, 1, 2'b01, 2'b00);            // cd 3->2, rc=1, pending kept
      check("R6 wait slot 1", grant_o, 0);
      check("R6 empty slot not marked", slot_mark_o, 0);
      check("R3 occupied bit passes", rq_out_bits_o, 1);
      cyc(1, 0, 0, 2'b00, 2'b00);
      check("R6 wait slot 2", grant_o, 0);
      cyc(1, 0, 0, 2'b00, 2'b00);
      check("R6 wait slot 3", grant_o, 0);
      cyc(1, 0, 0, 2'b00, 2'b00);
      check("R7 grant after countdown", grant_o, 1);
      cyc(0, 0, 1, 2'b00, 2'b00);
      check("R3 late insertion", rq_out_bits_o, 1);
      cyc(0, 0, 0, 2'b00, 2'b01);            // cd = 1 from request gathered while queued
      check("R3 pend cleared before strobe", busy_o, 0);
      cyc(1, 0, 0, 2'b00, 2'b00);
      check("R6 accumulated request served", grant_o, 0);
      cyc(1, 0, 0, 2'b00, 2'b00);
      check("R6 grant next cell", grant_o, 1);
      cyc(0, 0, 1, 2'b00, 2'b00);
   endtask

   task automatic t_floor();
      cyc(1, 0, 0, 2'b00, 2'b00);
      cyc(1, 0, 0, 2'b00, 2'b00);
      check("R4 idle empty no grant", grant_o, 0);
      cyc(0, 0, 0, 2'b00, 2'b01);
      cyc(1, 0, 0, 2'b00, 2'b00);
      check("R4 floor keeps count at zero", grant_o, 1);
      cyc(0, 0, 1, 2'b00, 2'b00);
      cyc(0, 0, 0, 2'b00, 2'b00);
      check("R4 idle again", busy_o, 0);
   endtask

   task automatic t_merge();
      cyc(0, 0, 0, 2'b00, 2'b01);
      cyc(1, 0, 0, 2'b00, 2'b00);
      check("R7 merge grant", grant_o, 1);
      cyc(0, 0, 1, 2'b01, 2'b00);             // rc_lo=1, pend kept
      cyc(0, 0, 0, 2'b00, 2'b00);
      check("R3 pend survives set bit", busy_o, 1);
      cyc(0, 0, 1, 2'b00, 2'b00);
      check("R3 insert into clear bit", rq_out_bits_o, 1);
      cyc(0, 0, 0, 2'b00, 2'b00);
      check("R3 pend gone", busy_o, 0);
      cyc(1, 0, 0, 2'b00, 2'b00);             // drains rc_lo
   endtask

   task automatic t_prio();
      cyc(0, 0, 1, 2'b10, 2'b00);
      check("R2 forward hi bit", rq_out_bits_o, 2);
      cyc(0, 0, 0, 2'b00, 2'b01);
      cyc(1, 0, 0, 2'b00, 2'b00);
      check("R9 lo held by hi count", grant_o, 0);
      cyc(1, 0, 0, 2'b00, 2'b00);
      check("R9 lo after hi drained", grant_o, 1);
      cyc(0, 0, 1, 2'b00, 2'b00);
      cyc(0, 0, 0, 2'b11, 2'b11);             // both at once
      cyc(1, 0, 0, 2'b00, 2'b00);
      check("R9 hi wins", grant_o, 2);
      cyc(1, 0, 0, 2'b00, 2'b00);
      check("R9 lo next", grant_o, 1);
      cyc(0, 0, 1, 2'b00, 2'b00);
      check("R2 both pending merged", rq_out_bits_o, 3);
      cyc(0, 0, 0, 2'b00, 2'b00);
      check("R9 all idle", busy_o, 0);
   endtask

   task automatic t_ignore();
      cyc(0, 0, 1, 2'b01, 2'b00);
      cyc(0, 0, 1, 2'b01, 2'b00);
      cyc(0, 0, 0, 2'b00, 2'b01);             // cd=2
      cyc(1, 0, 0, 2'b00, 2'b01);             // second strobe ignored, cd->1
      check("R5 wait 1", grant_o, 0);
      cyc(1, 0, 0, 2'b00, 2'b00);
      check("R5 wait 2", grant_o, 0);
      cyc(1, 0, 0, 2'b00, 2'b00);
      check("R5 single cell granted", grant_o, 1);
      cyc(1, 0, 0, 2'b00, 2'b00);
      check("R5 ignored strobe left no cell", grant_o, 0);
      cyc(0, 0, 1, 2'b00, 2'b00);
      cyc(0, 0, 0, 2'b00, 2'b00);
      check("R5 done", busy_o, 0);
   endtask

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_basic();
      t_count();
      t_floor();
      t_merge();
      t_prio();
      t_ignore();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule